// File: doc/BRIEF.md
# Hierarchical Fault Interrupt Controller

This block collects fault reports from the rest of a power-management chip into three 8-bit status registers, arranged as a tree, and raises an active-low interrupt line from them. Event faults such as emergency power-down, register CRC failure and eight vendor-defined faults arrive as one-cycle pulses. Condition faults, meaning enable-pin short, reset/interrupt pin fault, LDO fault and thermal shutdown, arrive as levels. A host reads the status registers through a simple register port and clears flags by writing ones.

The top register summarises the internal register, and the internal register summarises the vendor register. An interrupt handler can therefore read the top register first and go further down only when its summary bit is set. Summary bits cannot be written. They drop only when every bit below them has been cleared. A condition flag cannot be cleared while its fault input is still active, so a fault that is still present cannot be acknowledged by mistake. A software force bit can pull the interrupt line low at any time, for example to test the pin. A read-only bit reports the live level of the pin.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset, the registers at 0x10, 0x11, 0x12 and 0x20 read 0x00, the register at 0x21 reads 0x01, and irq_n is 1.
- R2: Reads are registered. rd_data shows the register that addr selected at the previous rising clock edge. The map is: 0x10 is the top status register, 0x11 is the internal status register, 0x12 is the vendor status register, 0x20 is control (bit 0 is the force bit, read/write), and 0x21 is pin status (bit 0, read-only). Unmapped addresses read 0x00.
- R3: A pulse on evt_emerg_pd sets 0x10 bit 6. A pulse on evt_crc_fault sets 0x11 bit 5. Writing 1 to either bit always clears it.
- R4: flt_en_short sets 0x10 bit 2, flt_pin_short sets 0x10 bit 0, flt_ldo sets 0x11 bit 3 and flt_thermal sets 0x11 bit 2. Each flag stays set while its input is high. A write of 1 has no effect while the input is high. Once the input is low, the flag stays set until a write of 1 clears it.
- R5: A pulse on evt_vendor[i] sets 0x12 bit i only when vendor_en[i] is 1. Writing 1 to a vendor bit clears it.
- R6: 0x11 bit 7 reads as the OR of all bits of 0x12. 0x10 bit 7 reads as the OR of all bits of 0x11, including its bit 7. Writing to either bit 7 has no effect.
- R7: Writing 0 to a status bit has no effect. Writing 1 to a bit that is 0, or to a reserved bit, has no effect. Reserved bits (0x10 bits 5:3 and 1, and 0x11 bits 6, 4, 1 and 0) always read 0.
- R8: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: irq_n is registered. It is 0 in the cycle after any bit of 0x10 reads 1 or the force bit is 1, and it is 1 otherwise.
- R10: 0x21 bit 0 reads the current irq_n level, so 1 means the interrupt is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data; for status registers a 1 requests a clear |
| rd_data | output | 8 | Registered read data |
| evt_emerg_pd | input | 1 | Emergency power-down event pulse |
| evt_crc_fault | input | 1 | Register CRC fault event pulse |
| flt_en_short | input | 1 | Enable-pin short condition level |
| flt_pin_short | input | 1 | Reset/interrupt pin fault condition level |
| flt_ldo | input | 1 | LDO fault condition level |
| flt_thermal | input | 1 | Thermal shutdown condition level |
| evt_vendor | input | 8 | Vendor fault event pulses |
| vendor_en | input | 8 | Per-bit enable mask for vendor faults |
| irq_n | output | 1 | Active-low interrupt output, registered |

## Verification
The assertions check, on every cycle, that a set request always leaves its flag set, that a flag changes only when it is set or cleared, that irq_n follows the top register and the force bit one cycle later, and that a vendor flag never rises while its enable is low. Some behaviour needs a written-out sequence of stimulus and is shown only by the bench scenarios: the read address map, the refusal to clear a condition flag while its fault is still active, writes to the summary bits being ignored, and the way the summary bits fall after the lower registers are cleared.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int DATA_W = 8;

  localparam logic [7:0] ADDR_TOP  = 8'h10;
  localparam logic [7:0] ADDR_INT  = 8'h11;
  localparam logic [7:0] ADDR_VND  = 8'h12;
  localparam logic [7:0] ADDR_CTRL = 8'h20;
  localparam logic [7:0] ADDR_PIN  = 8'h21;

  localparam int B_SUMMARY = 7;
  localparam int B_EMPD    = 6;
  localparam int B_ENSHORT = 2;
  localparam int B_PINFLT  = 0;
  localparam int B_CRC     = 5;
  localparam int B_LDO     = 3;
  localparam int B_THERM   = 2;

  localparam logic [DATA_W-1:0] TOP_STORED = 8'b0100_0101;
  localparam logic [DATA_W-1:0] INT_STORED = 8'b0010_1100;
  localparam logic [DATA_W-1:0] VND_STORED = 8'hFF;
endpackage

// File: rtl/fic_w1c_reg.sv
module fic_w1c_reg #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] STORED = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (STORED[b]) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst) q[b] <= 1'b0;
        else if (set_i[b]) q[b] <= 1'b1;
        else if (clr_i[b]) q[b] <= 1'b0;
      end
    end else begin : g_tie
      assign q[b] = 1'b0;
    end
  end

  // R8: a set request always wins
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((q & $past(set_i & STORED)) == $past(set_i & STORED)));

  // R7: a set bit stays set unless cleared
  a_r7_hold_set: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (($past(q) & ~$past(clr_i) & ~q) == '0));

  // R7: a clear bit rises only on a set request
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((~$past(q) & ~$past(set_i) & q) == '0));
endmodule

// File: rtl/fic_bus_port.sv
module fic_bus_port
  import fic_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] top_view,
  input  logic [DATA_W-1:0] int_view,
  input  logic [DATA_W-1:0] vnd_view,
  input  logic              pin_level,
  output logic [DATA_W-1:0] top_clr,
  output logic [DATA_W-1:0] int_clr,
  output logic [DATA_W-1:0] vnd_clr,
  output logic              force_q,
  output logic [DATA_W-1:0] rd_data
);
  logic sel_top, sel_int, sel_vnd, sel_ctrl, sel_pin;

  assign sel_top  = (addr == ADDR_W'(ADDR_TOP));
  assign sel_int  = (addr == ADDR_W'(ADDR_INT));
  assign sel_vnd  = (addr == ADDR_W'(ADDR_VND));
  assign sel_ctrl = (addr == ADDR_W'(ADDR_CTRL));
  assign sel_pin  = (addr == ADDR_W'(ADDR_PIN));

  assign top_clr = (wr_en && sel_top) ? wr_data : '0;
  assign int_clr = (wr_en && sel_int) ? wr_data : '0;
  assign vnd_clr = (wr_en && sel_vnd) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) force_q <= 1'b0;
    else if (wr_en && sel_ctrl) force_q <= wr_data[0];
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (sel_top)  rd_next = top_view;
    if (sel_int)  rd_next = int_view;
    if (sel_vnd)  rd_next = vnd_view;
    if (sel_ctrl) rd_next = {{(DATA_W-1){1'b0}}, force_q};
    if (sel_pin)  rd_next = {{(DATA_W-1){1'b0}}, pin_level};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else rd_data <= rd_next;
  end

  // R2: the force bit changes only through a control write
  a_r2_force_write_only: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel_ctrl) |=> $stable(force_q));
endmodule

// File: rtl/fic_irq_drv.sv
module fic_irq_drv (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic force_i,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else irq_n <= ~(pending | force_i);
  end
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fic_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              evt_emerg_pd,
  input  logic              evt_crc_fault,
  input  logic              flt_en_short,
  input  logic              flt_pin_short,
  input  logic              flt_ldo,
  input  logic              flt_thermal,
  input  logic [DATA_W-1:0] evt_vendor,
  input  logic [DATA_W-1:0] vendor_en,
  output logic              irq_n
);
  logic [DATA_W-1:0] top_q, int_q, vnd_q;
  logic [DATA_W-1:0] top_set, int_set, vnd_set;
  logic [DATA_W-1:0] top_clr, int_clr, vnd_clr;
  logic [DATA_W-1:0] top_view, int_view, vnd_view;
  logic              force_q;

  always_comb begin
    top_set = '0;
    top_set[B_EMPD]    = evt_emerg_pd;
    top_set[B_ENSHORT] = flt_en_short;
    top_set[B_PINFLT]  = flt_pin_short;
    int_set = '0;
    int_set[B_CRC]   = evt_crc_fault;
    int_set[B_LDO]   = flt_ldo;
    int_set[B_THERM] = flt_thermal;
  end
  assign vnd_set = evt_vendor & vendor_en;

  fic_w1c_reg #(.WIDTH(DATA_W), .STORED(TOP_STORED)) u_top (
    .clk(clk), .rst(rst), .set_i(top_set), .clr_i(top_clr), .q(top_q));
  fic_w1c_reg #(.WIDTH(DATA_W), .STORED(INT_STORED)) u_int (
    .clk(clk), .rst(rst), .set_i(int_set), .clr_i(int_clr), .q(int_q));
  fic_w1c_reg #(.WIDTH(DATA_W), .STORED(VND_STORED)) u_vnd (
    .clk(clk), .rst(rst), .set_i(vnd_set), .clr_i(vnd_clr), .q(vnd_q));

  always_comb begin
    vnd_view = vnd_q;
    int_view = int_q;
    int_view[B_SUMMARY] = |vnd_view;
    top_view = top_q;
    top_view[B_SUMMARY] = |int_view;
  end

  fic_bus_port #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .top_view(top_view), .int_view(int_view), .vnd_view(vnd_view),
    .pin_level(irq_n), .top_clr(top_clr), .int_clr(int_clr),
    .vnd_clr(vnd_clr), .force_q(force_q), .rd_data(rd_data));

  fic_irq_drv u_irq (
    .clk(clk), .rst(rst), .pending(|top_view), .force_i(force_q),
    .irq_n(irq_n));

  // R9: pending status drives the line low next cycle
  a_r9_irq_low: assert property (@(posedge clk) disable iff (rst)
    (vnd_q != '0 || int_q != '0 || top_q != '0) |=> !irq_n);

  // R9: no cause means the line is released next cycle
  a_r9_irq_high: assert property (@(posedge clk) disable iff (rst)
    (vnd_q == '0 && int_q == '0 && top_q == '0 && !force_q) |=> irq_n);

  // R5: a masked vendor fault never raises its flag
  a_r5_vendor_masked: assert property (@(posedge clk) disable iff (rst)
    ((~vendor_en & ~vnd_q) != '0) |=> ((~$past(vendor_en) & ~$past(vnd_q) & vnd_q) == '0));

  // R4: an active condition keeps its flag set
  a_r4_level_sticky: assert property (@(posedge clk) disable iff (rst)
    flt_ldo |=> int_q[B_LDO]);
endmodule

// File: tb/fault_irq_ctrl_test.sv
module fault_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       evt_emerg_pd = 1'b0, evt_crc_fault = 1'b0;
  logic       flt_en_short = 1'b0, flt_pin_short = 1'b0;
  logic       flt_ldo = 1'b0, flt_thermal = 1'b0;
  logic [7:0] evt_vendor = '0, vendor_en = '0;
  logic       irq_n;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  fault_irq_ctrl uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt_emerg_pd(evt_emerg_pd), .evt_crc_fault(evt_crc_fault),
    .flt_en_short(flt_en_short), .flt_pin_short(flt_pin_short),
    .flt_ldo(flt_ldo), .flt_thermal(flt_thermal), .evt_vendor(evt_vendor),
    .vendor_en(vendor_en), .irq_n(irq_n));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    rd_check("R1 top", 8'h10, 8'h00);
    rd_check("R1 int", 8'h11, 8'h00);
    rd_check("R1 vnd", 8'h12, 8'h00);
    rd_check("R1 ctrl", 8'h20, 8'h00);
    rd_check("R1 pin", 8'h21, 8'h01);
    rd_check("R2 unmapped", 8'h33, 8'h00);
  endtask

  task automatic t_events;
    @(negedge clk); evt_emerg_pd = 1'b1;
    @(negedge clk); evt_emerg_pd = 1'b0;
    rd_check("R3 empd set", 8'h10, 8'h40);
    check("R9 irq asserted", {7'd0, irq_n}, 8'h00);
    wr(8'h10, 8'h40);
    rd_check("R3 empd cleared", 8'h10, 8'h00);
    check("R9 irq released", {7'd0, irq_n}, 8'h01);
    @(negedge clk); evt_crc_fault = 1'b1;
    @(negedge clk); evt_crc_fault = 1'b0;
    rd_check("R3 crc set", 8'h11, 8'h20);
    rd_check("R6 top summary", 8'h10, 8'h80);
    wr(8'h10, 8'h80);
    rd_check("R6 summary not writable", 8'h10, 8'h80);
    wr(8'h11, 8'h20);
    rd_check("R3 crc cleared", 8'h11, 8'h00);
    rd_check("R6 summary dropped", 8'h10, 8'h00);
  endtask

  task automatic t_levels;
    @(negedge clk); flt_ldo = 1'b1;
    rd_check("R4 ldo set", 8'h11, 8'h08);
    wr(8'h11, 8'h08);
    rd_check("R4 ldo clear refused", 8'h11, 8'h08);
    @(negedge clk); flt_ldo = 1'b0;
    rd_check("R4 ldo sticky", 8'h11, 8'h08);
    wr(8'h11, 8'h08);
    rd_check("R4 ldo cleared", 8'h11, 8'h00);
    @(negedge clk); flt_pin_short = 1'b1; flt_thermal = 1'b1;
    wr(8'h10, 8'h01);
    rd_check("R4 pin clear refused", 8'h10, 8'h81);
    @(negedge clk); flt_pin_short = 1'b0; flt_thermal = 1'b0;
    wr(8'h10, 8'h01);
    wr(8'h11, 8'h04);
    rd_check("R4 pin cleared", 8'h10, 8'h00);
    @(negedge clk); flt_en_short = 1'b1;
    @(negedge clk); flt_en_short = 1'b0;
    rd_check("R4 en short set", 8'h10, 8'h04);
    wr(8'h10, 8'h04);
    rd_check("R4 en short cleared", 8'h10, 8'h00);
  endtask

  task automatic t_vendor;
    vendor_en = 8'h0F;
    @(negedge clk); evt_vendor = 8'hFF;
    @(negedge clk); evt_vendor = 8'h00;
    rd_check("R5 masked set", 8'h12, 8'h0F);
    rd_check("R6 int summary", 8'h11, 8'h80);
    rd_check("R6 top summary chain", 8'h10, 8'h80);
    wr(8'h12, 8'h03);
    rd_check("R5 partial clear", 8'h12, 8'h0C);
    wr(8'h11, 8'h80);
    rd_check("R6 int summary not writable", 8'h11, 8'h80);
    wr(8'h12, 8'hFF);
    rd_check("R5 vendor cleared", 8'h12, 8'h00);
    rd_check("R6 int summary dropped", 8'h11, 8'h00);
    rd_check("R6 top summary dropped", 8'h10, 8'h00);
    vendor_en = 8'h00;
  endtask

  task automatic t_write_rules;
    @(negedge clk); evt_emerg_pd = 1'b1;
    @(negedge clk); evt_emerg_pd = 1'b0;
    wr(8'h10, 8'h00);
    rd_check("R7 write zero", 8'h10, 8'h40);
    wr(8'h10, 8'hBF);
    rd_check("R7 write one to zero bits", 8'h10, 8'h40);
    @(negedge clk);
    addr = 8'h10; wr_data = 8'h40; wr_en = 1'b1; evt_emerg_pd = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; evt_emerg_pd = 1'b0;
    rd_check("R8 set wins", 8'h10, 8'h40);
    wr(8'h10, 8'h40);
    rd_check("R7 final clear", 8'h10, 8'h00);
  endtask

  task automatic t_force;
    wr(8'h20, 8'h01);
    rd_check("R2 ctrl readback", 8'h20, 8'h01);
    check("R9 forced low", {7'd0, irq_n}, 8'h00);
    rd_check("R10 pin low", 8'h21, 8'h00);
    wr(8'h20, 8'h00);
    @(negedge clk);
    check("R9 force released", {7'd0, irq_n}, 8'h01);
    rd_check("R10 pin high", 8'h21, 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_events();
    t_levels();
    t_vendor();
    t_write_rules();
    t_force();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule